// File: doc/BRIEF.md
# Prescaled Three-Channel Timer Bank

The block holds three down-counting timers that all run from one base clock, each through its own fixed prescaler: timer 0 advances once every ten clocks, and timers 1 and 2 advance once every thousand. Timers 0 and 1 are 16 bits wide. Timer 2 is 24 bits wide. A host reaches the bank through a 16-bit register port. A select register names the target timer and also drives four general-purpose output pins. Writing the data register then loads the divisor of that target, and reading the data register returns its live count. The upper eight bits of timer 2 are reached with a select code of their own.

Each timer takes a 2-bit mode code: one-shot with interrupt on terminal count, free-running rate generator, software-started strobe, or hardware-started strobe. A gate bit in the control register lets a timer count or freezes it. Every terminal count gives a one-clock pulse on that timer's output. On timer 2, a terminal count also sets a sticky interrupt flag, and a read of the select register clears it.

Top module: `tmr_bank3`

## Requirements
- R1: After reset every count, the selected target, the output pins, the mode register, the gate bits and the interrupt flag read as zero, and every address reads back 0x0000.
- R2: A write to address 0 stores the target code from data bits 1:0 and drives data bits 7:4 onto `doBits`. Every such write updates the pins, and no other access changes them.
- R3: A write to address 1 loads the divisor of the selected target and restarts that timer's count. Codes 0, 1 and 2 take the low 16 bits of timers 0, 1 and 2. Code 3 takes data bits 7:0 as bits 23:16 of timer 2. A read of address 1 returns the live count of the same target, with code 3 returning count bits 23:16 in bits 7:0.
- R4: A divisor below 2 is counted as 2.
- R5: While its gate is set, timer 0 decrements once every 10 clocks and timers 1 and 2 once every 1000 clocks. Gate n is bit 12+n of the control register at address 3.
- R6: While its gate bit is clear, a timer holds its count and its prescaler phase and produces no pulse.
- R7: The mode register at address 2 holds the code of timer n in bits 2n+1:2n. The codes are 0 for one-shot with interrupt, 1 for rate generator, 2 for software strobe and 3 for hardware strobe. In code 1 the timer reloads its divisor at terminal count and pulses `tcPulse[n]` for exactly one clock, once every divisor ticks.
- R8: In codes 0 and 2, a divisor write starts one countdown. That countdown gives one pulse and then leaves the count at zero until the next divisor write.
- R9: In code 3, a divisor write loads the count without starting it. Each rising edge of `hwTrig[n]` restarts the countdown from the stored divisor.
- R10: A timer 2 pulse sets `irqFlag` on the next clock. The flag stays set and reads as bit 12 at address 4.
- R11: A read of address 0 clears `irqFlag` on the next clock, unless a timer 2 pulse is present in that same cycle, in which case the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effects only) |
| addr | input | 3 | Register address |
| wrData | input | 16 | Write data |
| hwTrig | input | 3 | Hardware start inputs, one per timer |
| rdData | output | 16 | Read data for `addr`, combinational |
| doBits | output | 4 | General-purpose output pins |
| tcPulse | output | 3 | One-clock terminal-count pulse per timer |
| irqFlag | output | 1 | Sticky timer 2 terminal-count flag |

## Verification
The properties assume that the host presents one register access per clock and never raises `wrEn` and `rdEn` together. They also assume that every prescaler is at least 2, because a one-clock pulse cannot be told apart from a back-to-back one otherwise. The stimulus issues accesses only through write and read tasks that each hold the port for a single clock and then idle it. The bench keeps the default prescalers. It drives each hardware start input as a clean rising edge with a low clock on each side, so a start is never taken for a retrigger.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int HOST_W   = 16;
  localparam int NUM_TMR  = 3;
  localparam int SEL_W    = 2;
  localparam int DO_W     = 4;
  localparam int DO_LSB   = 4;
  localparam int GATE_LSB = 12;
  localparam int FLAG_BIT = 12;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] ADR_SEL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_DATA = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_MODE = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd4;

  typedef enum logic [1:0] {
    MODE_TERM  = 2'd0,
    MODE_RATE  = 2'd1,
    MODE_SWSTB = 2'd2,
    MODE_HWSTB = 2'd3
  } tmrModeT;

  typedef struct packed {
    logic [NUM_TMR-1:0] loadLow;
    logic               loadHigh;
    logic [HOST_W-1:0]  data;
  } tmrStrobeT;
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int PRESCALE = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              gate,
  input  tmrModeT           mode,
  input  logic              loadLow,
  input  logic              loadHigh,
  input  logic [HOST_W-1:0] wrData,
  input  logic              hwTrig,
  output logic [WIDTH-1:0]  count,
  output logic              tcPulse
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
  localparam logic [WIDTH-1:0] MIN_DIV = WIDTH'(2);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] divReg;
  logic [WIDTH-1:0] divNext;
  logic [WIDTH-1:0] effNew;
  logic [WIDTH-1:0] effStored;
  logic [PW-1:0]    preCnt;
  logic             running;
  logic             trigPrev;
  logic             load;
  logic             trigRise;

  generate
    if (WIDTH > HOST_W) begin : g_wide
      always_comb begin
        divNext = divReg;
        if (loadLow)  divNext[HOST_W-1:0]     = wrData;
        if (loadHigh) divNext[WIDTH-1:HOST_W] = wrData[WIDTH-HOST_W-1:0];
      end
    end else begin : g_narrow
      always_comb begin
        divNext = divReg;
        if (loadLow) divNext = wrData[WIDTH-1:0];
      end
    end
  endgenerate

  assign effNew    = (divNext < MIN_DIV) ? MIN_DIV : divNext;
  assign effStored = (divReg  < MIN_DIV) ? MIN_DIV : divReg;
  assign load      = loadLow | loadHigh;
  assign trigRise  = hwTrig & ~trigPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg   <= '0;
      count    <= '0;
      preCnt   <= '0;
      running  <= 1'b0;
      tcPulse  <= 1'b0;
      trigPrev <= 1'b0;
    end else begin
      trigPrev <= hwTrig;
      tcPulse  <= 1'b0;
      divReg   <= divNext;
      if (load) begin
        count   <= effNew;
        preCnt  <= '0;
        running <= (mode != MODE_HWSTB);
      end else if (mode == MODE_HWSTB && trigRise) begin
        count   <= effStored;
        preCnt  <= '0;
        running <= 1'b1;
      end else if (gate && running) begin
        if (preCnt == PRE_LAST) begin
          preCnt <= '0;
          if (count == ONE) begin
            tcPulse <= 1'b1;
            if (mode == MODE_RATE) begin
              count <= effStored;
            end else begin
              count   <= '0;
              running <= 1'b0;
            end
          end else begin
            count <= count - ONE;
          end
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int WIDTH_HI = 24,
  parameter int PRE0     = 10,
  parameter int PRE1     = 1000,
  parameter int PRE2     = 1000
) (
  input  logic                clk,
  input  logic                rstN,
  input  tmrStrobeT           strobe,
  input  logic [NUM_TMR-1:0]  gates,
  input  tmrModeT             modes [NUM_TMR],
  input  logic [NUM_TMR-1:0]  hwTrig,
  output logic [HOST_W-1:0]   cnt0,
  output logic [HOST_W-1:0]   cnt1,
  output logic [WIDTH_HI-1:0] cnt2,
  output logic [NUM_TMR-1:0]  tcPulse
);
  generate
    for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_ch
      localparam int W   = (gi == NUM_TMR - 1) ? WIDTH_HI : HOST_W;
      localparam int PRE = (gi == 0) ? PRE0 : ((gi == 1) ? PRE1 : PRE2);
      logic [W-1:0] chCount;
      logic         hiLoad;

      if (gi == NUM_TMR - 1) begin : g_hi
        assign hiLoad = strobe.loadHigh;
      end else begin : g_nohi
        assign hiLoad = 1'b0;
      end

      tmr_chan #(.WIDTH(W), .PRESCALE(PRE)) u_chan (
        .clk      (clk),
        .rstN     (rstN),
        .gate     (gates[gi]),
        .mode     (modes[gi]),
        .loadLow  (strobe.loadLow[gi]),
        .loadHigh (hiLoad),
        .wrData   (strobe.data),
        .hwTrig   (hwTrig[gi]),
        .count    (chCount),
        .tcPulse  (tcPulse[gi])
      );

      if (gi == 0) begin : g_o0
        assign cnt0 = chCount;
      end else if (gi == 1) begin : g_o1
        assign cnt1 = chCount;
      end else begin : g_o2
        assign cnt2 = chCount;
      end
    end
  endgenerate
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int WIDTH_HI = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [HOST_W-1:0]   wrData,
  input  logic [HOST_W-1:0]   cnt0,
  input  logic [HOST_W-1:0]   cnt1,
  input  logic [WIDTH_HI-1:0] cnt2,
  input  logic                tcLast,
  output tmrStrobeT           strobe,
  output logic [NUM_TMR-1:0]  gates,
  output tmrModeT             modes [NUM_TMR],
  output logic [DO_W-1:0]     doBits,
  output logic                irqFlag,
  output logic [HOST_W-1:0]   rdData
);
  localparam int MODE_W = 2 * NUM_TMR;

  logic [SEL_W-1:0]  selReg;
  logic [MODE_W-1:0] modeReg;
  logic              dataWr;

  assign dataWr = wrEn && (addr == ADR_DATA);

  always_comb begin
    strobe          = '0;
    strobe.data     = wrData;
    if (dataWr) begin
      if (selReg == SEL_W'(NUM_TMR)) strobe.loadHigh = 1'b1;
      else                           strobe.loadLow[selReg] = 1'b1;
    end
  end

  generate
    for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_mode
      assign modes[gi] = tmrModeT'(modeReg[2*gi +: 2]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg  <= '0;
      doBits  <= '0;
      modeReg <= '0;
      gates   <= '0;
      irqFlag <= 1'b0;
    end else begin
      if (wrEn) begin
        case (addr)
          ADR_SEL: begin
            selReg <= wrData[SEL_W-1:0];
            doBits <= wrData[DO_LSB +: DO_W];
          end
          ADR_MODE: modeReg <= wrData[MODE_W-1:0];
          ADR_CTRL: gates   <= wrData[GATE_LSB +: NUM_TMR];
          default: ;
        endcase
      end
      if (tcLast)
        irqFlag <= 1'b1;
      else if (rdEn && addr == ADR_SEL)
        irqFlag <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADR_SEL: begin
        rdData[SEL_W-1:0]       = selReg;
        rdData[DO_LSB +: DO_W]  = doBits;
      end
      ADR_DATA: begin
        case (selReg)
          2'd0:    rdData = cnt0;
          2'd1:    rdData = cnt1;
          2'd2:    rdData = cnt2[HOST_W-1:0];
          default: rdData = HOST_W'(cnt2[WIDTH_HI-1:HOST_W]);
        endcase
      end
      ADR_MODE: rdData[MODE_W-1:0] = modeReg;
      ADR_CTRL: rdData[GATE_LSB +: NUM_TMR] = gates;
      ADR_STAT: rdData[FLAG_BIT] = irqFlag;
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_bank3.sv
module tmr_bank3
  import tmr_pkg::*;
#(
  parameter int WIDTH_HI = 24,
  parameter int PRE0     = 10,
  parameter int PRE1     = 1000,
  parameter int PRE2     = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [2:0]  addr,
  input  logic [15:0] wrData,
  input  logic [2:0]  hwTrig,
  output logic [15:0] rdData,
  output logic [3:0]  doBits,
  output logic [2:0]  tcPulse,
  output logic        irqFlag
);
  tmrStrobeT           strobe;
  logic [NUM_TMR-1:0]  gates;
  tmrModeT             modes [NUM_TMR];
  logic [HOST_W-1:0]   cnt0;
  logic [HOST_W-1:0]   cnt1;
  logic [WIDTH_HI-1:0] cnt2;

  tmr_ctrl #(.WIDTH_HI(WIDTH_HI)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .wrData  (wrData),
    .cnt0    (cnt0),
    .cnt1    (cnt1),
    .cnt2    (cnt2),
    .tcLast  (tcPulse[NUM_TMR-1]),
    .strobe  (strobe),
    .gates   (gates),
    .modes   (modes),
    .doBits  (doBits),
    .irqFlag (irqFlag),
    .rdData  (rdData)
  );

  tmr_datapath #(
    .WIDTH_HI (WIDTH_HI),
    .PRE0     (PRE0),
    .PRE1     (PRE1),
    .PRE2     (PRE2)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .gates   (gates),
    .modes   (modes),
    .hwTrig  (hwTrig),
    .cnt0    (cnt0),
    .cnt1    (cnt1),
    .cnt2    (cnt2),
    .tcPulse (tcPulse)
  );
endmodule

// File: rtl/tmr_bank3_chk.sv
module tmr_bank3_chk #(
  parameter int PRE0 = 10,
  parameter int PRE1 = 1000,
  parameter int PRE2 = 1000
) (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rdEn,
  input logic [2:0] addr,
  input logic [2:0] tcPulse,
  input logic [3:0] doBits,
  input logic       irqFlag
);
  localparam int PRES [3] = '{PRE0, PRE1, PRE2};

  // R10: a timer 2 pulse raises the flag on the next clock
  assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    tcPulse[2] |=> irqFlag);

  // R10: the flag is sticky until cleared by a select read
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !(rdEn && addr == 3'd0)) |=> irqFlag);

  // R10: the flag rises only after a timer 2 pulse
  assert_flag_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!irqFlag && !tcPulse[2]) |=> !irqFlag);

  // R11: a select read with no coincident pulse clears the flag
  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 3'd0 && !tcPulse[2]) |=> !irqFlag);

  // R2: output pins change only on a select write
  assert_pins_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == 3'd0) |=> $stable(doBits));

  generate
    for (genvar gi = 0; gi < 3; gi++) begin : g_pw
      if (PRES[gi] > 1) begin : g_on
        // R7: every terminal-count pulse lasts exactly one clock
        assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rstN)
          tcPulse[gi] |=> !tcPulse[gi]);
      end
    end
  endgenerate
endmodule

bind tmr_bank3 tmr_bank3_chk #(.PRE0(PRE0), .PRE1(PRE1), .PRE2(PRE2)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .rdEn    (rdEn),
  .addr    (addr),
  .tcPulse (tcPulse),
  .doBits  (doBits),
  .irqFlag (irqFlag)
);

// File: tb/tmr_bank3_bench.sv
module tmr_bank3_bench;
  localparam int P0 = 10;
  localparam int P1 = 1000;
  localparam int P2 = 1000;
  localparam int WDOG = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [2:0]  hwTrig = '0;
  logic [15:0] rdData;
  logic [3:0]  doBits;
  logic [2:0]  tcPulse;
  logic        irqFlag;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  tmr_bank3 #(.PRE0(P0), .PRE1(P1), .PRE2(P2)) u_tmr_bank3 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .hwTrig(hwTrig), .rdData(rdData), .doBits(doBits),
    .tcPulse(tcPulse), .irqFlag(irqFlag)
  );

  always #2 clk = ~clk;

  // behavioural reference model
  int mDiv [3];
  int mCnt [3];
  int mPre [3];
  bit mRun [3];
  bit mPulse [3];
  bit mPrev [3];
  int mSel, mDo, mMode, mGate;
  bit mFlag;

  function automatic int effDiv(int d);
    return (d < 2) ? 2 : d;
  endfunction

  function automatic int preOf(int n);
    return (n == 0) ? P0 : ((n == 1) ? P1 : P2);
  endfunction

  function automatic int modelRead(int a);
    case (a)
      0: return (mDo << 4) | mSel;
      1: return (mSel == 3) ? ((mCnt[2] >> 16) & 255) : (mCnt[mSel] & 16'hFFFF);
      2: return mMode;
      3: return mGate << 12;
      4: return int'(mFlag) << 12;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int n = 0; n < 3; n++) begin
        mDiv[n] = 0; mCnt[n] = 0; mPre[n] = 0;
        mRun[n] = 0; mPulse[n] = 0; mPrev[n] = 0;
      end
      mSel = 0; mDo = 0; mMode = 0; mGate = 0; mFlag = 0;
    end else begin
      if (mPulse[2]) mFlag = 1;
      else if (rdEn && addr == 3'd0) mFlag = 0;
      for (int n = 0; n < 3; n++) begin
        int md;
        bit ld;
        bit rise;
        md = (mMode >> (2 * n)) & 3;
        ld = wrEn && addr == 3'd1 && (mSel == n || (n == 2 && mSel == 3));
        rise = hwTrig[n] && !mPrev[n];
        mPulse[n] = 0;
        if (ld) begin
          if (n == 2 && mSel == 3) mDiv[2] = (mDiv[2] & 16'hFFFF) | ((int'(wrData) & 255) << 16);
          else if (n == 2) mDiv[2] = (mDiv[2] & 32'hFF0000) | int'(wrData);
          else mDiv[n] = int'(wrData);
          mCnt[n] = effDiv(mDiv[n]);
          mPre[n] = 0;
          mRun[n] = (md != 3);
        end else if (md == 3 && rise) begin
          mCnt[n] = effDiv(mDiv[n]);
          mPre[n] = 0;
          mRun[n] = 1;
        end else if (((mGate >> n) & 1) == 1 && mRun[n]) begin
          if (mPre[n] == preOf(n) - 1) begin
            mPre[n] = 0;
            if (mCnt[n] == 1) begin
              mPulse[n] = 1;
              if (md == 1) mCnt[n] = effDiv(mDiv[n]);
              else begin mCnt[n] = 0; mRun[n] = 0; end
            end else mCnt[n] = mCnt[n] - 1;
          end else mPre[n] = mPre[n] + 1;
        end
        mPrev[n] = hwTrig[n];
      end
      if (wrEn) begin
        case (addr)
          3'd0: begin mSel = int'(wrData) & 3; mDo = (int'(wrData) >> 4) & 15; end
          3'd2: mMode = int'(wrData) & 255;
          3'd3: mGate = (int'(wrData) >> 12) & 7;
          default: ;
        endcase
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rstN && !done) begin
      for (int n = 0; n < 3; n++)
        check("R7 tcPulse vs model", 32'(tcPulse[n]), 32'(mPulse[n]));
      check("R10 irqFlag vs model", 32'(irqFlag), 32'(mFlag));
      check("R2 doBits vs model", 32'(doBits), 32'(mDo));
      check("R3 rdData vs model", 32'(rdData), 32'(modelRead(int'(addr))));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic countPulses(input int cycles, input int idx, output int c);
    c = 0;
    repeat (cycles) begin
      @(negedge clk);
      #1;
      if (tcPulse[idx]) c++;
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] v2;
    int c;
    int gap;

    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check("R1 reset readback", 32'(v), 32'h0);
    end
    check("R1 reset pins", 32'(doBits), 32'h0);
    check("R1 reset flag", 32'(irqFlag), 32'h0);

    // R2: select register drives the pins
    wr(3'd0, 16'h00A0);
    check("R2 pins after select write", 32'(doBits), 32'hA);
    wr(3'd0, 16'h0051);
    check("R2 pins updated again", 32'(doBits), 32'h5);
    rd(3'd0, v);
    check("R2 select readback", 32'(v), 32'h51);

    // R7 R5: timer 0 as rate generator, divisor 3 -> period 30 clocks
    wr(3'd2, 16'h0001);
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'd3);
    rd(3'd1, v);
    check("R3 count after load", 32'(v), 32'd3);
    wr(3'd3, 16'h1000);
    countPulses(295, 0, c);
    check("R7 rate pulses in window", 32'(c), 32'd9);
    gap = 0;
    do begin @(negedge clk); #1; end while (!tcPulse[0]);
    do begin @(negedge clk); #1; gap++; end while (!tcPulse[0]);
    check("R5 timer0 period", 32'(gap), 32'd30);
    rd(3'd1, v);
    check("R3 live count in range", 32'(v >= 1 && v <= 3), 32'd1);

    // R6: gate cleared freezes the timer
    wr(3'd3, 16'h0000);
    rd(3'd1, v);
    countPulses(50, 0, c);
    rd(3'd1, v2);
    check("R6 count frozen", 32'(v2), 32'(v));
    check("R6 no pulses while gated off", 32'(c), 32'd0);

    // R4 R8 R5: timer 1 one-shot with divisor 0 -> treated as 2
    wr(3'd2, 16'h0001);
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'd0);
    rd(3'd1, v);
    check("R4 divisor clamped", 32'(v), 32'd2);
    wr(3'd3, 16'h2000);
    countPulses(1900, 1, c);
    check("R5 timer1 not early", 32'(c), 32'd0);
    countPulses(600, 1, c);
    check("R8 single pulse", 32'(c), 32'd1);
    rd(3'd1, v);
    check("R8 count parked at zero", 32'(v), 32'd0);
    countPulses(1100, 1, c);
    check("R8 no further pulse", 32'(c), 32'd0);

    // R3: timer 2 loaded in two halves
    wr(3'd2, 16'h0000);
    wr(3'd0, 16'h0002);
    wr(3'd1, 16'd3);
    wr(3'd0, 16'h0003);
    wr(3'd1, 16'h0001);
    rd(3'd1, v);
    check("R3 timer2 upper readback", 32'(v), 32'h1);
    wr(3'd0, 16'h0002);
    rd(3'd1, v);
    check("R3 timer2 lower readback", 32'(v), 32'h3);

    // R10 R11: timer 2 terminal count sets the flag
    wr(3'd0, 16'h0003);
    wr(3'd1, 16'h0000);
    wr(3'd3, 16'h4000);
    check("R10 flag clear before count", 32'(irqFlag), 32'h0);
    c = 0;
    while (!tcPulse[2] && c < 4000) begin @(negedge clk); #1; c++; end
    check("R5 timer2 period", 32'(c > 2900 && c < 3100), 32'd1);
    @(negedge clk); #1;
    check("R10 flag set after pulse", 32'(irqFlag), 32'h1);
    rd(3'd4, v);
    check("R10 status bit", 32'(v), 32'h1000);
    rd(3'd0, v);
    rd(3'd4, v);
    check("R11 flag cleared by select read", 32'(v), 32'h0000);

    // R9: timer 1 hardware-started strobe
    wr(3'd2, 16'h000C);
    wr(3'd3, 16'h2000);
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'd2);
    countPulses(2500, 1, c);
    check("R9 no count without trigger", 32'(c), 32'd0);
    rd(3'd1, v);
    check("R9 count held at divisor", 32'(v), 32'd2);
    @(negedge clk); hwTrig = 3'b010;
    @(negedge clk); hwTrig = 3'b000;
    countPulses(2500, 1, c);
    check("R9 one pulse after trigger", 32'(c), 32'd1);
    rd(3'd1, v);
    check("R9 count zero after strobe", 32'(v), 32'd0);

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule